// File: doc/BRIEF.md
# Dual-lane ADC ramp pattern checker

This block checks captured ADC data while the converter outputs a counting test pattern. Each of the two lanes (in-phase and quadrature) gets its own checker. A checker starts looking for the pattern when the shared enable goes high, and it aligns on the first valid sample whose value is zero. After that it predicts every following valid sample as the previous one plus one, wrapping at the sample width. Each sample that does not match the prediction adds one to that lane's error tally.

Calibration firmware uses the block to sweep a capture or clock delay. At each delay setting it re-arms the checkers by driving enable low and then high, waits, and then reads each lane's lock flag and error tally. Reporting lock and errors separately shows two different results apart: a lane that never aligned (for example a lane held at all-ones) and a lane that aligned but saw errors.

Top module: `ramp_chk_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both lock flags are low and both error tallies read zero.
- R2: When enable is sampled low at a clock edge, both lanes show lock low and tally zero after that edge. While enable stays low, no sample, including zero, sets lock.
- R3: While enabled and not locked, a lane sets its lock flag one cycle after it accepts a valid sample equal to zero. Nonzero samples, including the all-ones word, never set lock.
- R4: Once a lane is locked, the first expected value is 1. Each later expected value is the previous accepted sample plus one, modulo 2^SMP_W, so the all-ones value followed by zero counts as correct.
- R5: Each valid sample that differs from the expected value raises the tally by exactly one, one cycle later. The expected value then resynchronises to that sample plus one, so a single slip in the ramp costs one error.
- R6: The error tally saturates at 2^ERR_W-1 and does not wrap.
- R7: A sample presented with valid low has no effect on lock, tally or the expected value. Lock and tally hold steady while enable stays high.
- R8: The two lanes are independent. Each lane's lock and tally depend only on its own sample input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Arms both checkers while high; low clears them |
| smp_valid | input | 1 | Qualifies the current samples on both lanes |
| smp_i | input | SMP_W | In-phase lane sample |
| smp_q | input | SMP_W | Quadrature lane sample |
| lock_i | output | 1 | In-phase lane has aligned on zero |
| lock_q | output | 1 | Quadrature lane has aligned on zero |
| errs_i | output | ERR_W | In-phase mismatch tally, saturating |
| errs_q | output | ERR_W | Quadrature mismatch tally, saturating |

## Verification
The bench builds the block with SMP_W=4 and ERR_W=3. A 16-value ramp then wraps several times within a short run, and a 3-bit tally reaches saturation after seven mismatches. These values make it possible to sweep every slip distance from 1 to 15 on one lane while the other lane stays clean or is held at all-ones. The expected lock and tally of each lane are recomputed every cycle from modular arithmetic on the applied samples.

// File: rtl/ramp_chk_pkg.sv
package ramp_chk_pkg;
    typedef enum logic {
        ARMING   = 1'b0,
        TRACKING = 1'b1
    } lane_mode_e;
endpackage

// File: rtl/err_tally.sv
module err_tally #(
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bump,
    output logic [ERR_W-1:0] count
);
    localparam logic [ERR_W-1:0] TOP = {ERR_W{1'b1}};

    logic [ERR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (bump && cnt_q != TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_q == TOP) |=> (count == TOP));

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && bump && cnt_q != TOP) |=> (count == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/ramp_lane.sv
module ramp_lane
    import ramp_chk_pkg::*;
#(
    parameter int SMP_W = 14,
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp,
    output logic             locked,
    output logic [ERR_W-1:0] errs
);
    typedef struct packed {
        lane_mode_e       mode;
        logic [SMP_W-1:0] expect_v;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     miss_d;

    always_comb begin
        st_d   = st_q;
        miss_d = 1'b0;
        if (!enable) begin
            st_d.mode     = ARMING;
            st_d.expect_v = '0;
        end else if (smp_valid) begin
            unique case (st_q.mode)
                ARMING: begin
                    if (smp == '0) begin
                        st_d.mode     = TRACKING;
                        st_d.expect_v = smp + 1'b1;
                    end
                end
                TRACKING: begin
                    miss_d        = (smp != st_q.expect_v);
                    st_d.expect_v = smp + 1'b1;
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode     <= ARMING;
            st_q.expect_v <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    err_tally #(.ERR_W(ERR_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!enable),
        .bump  (miss_d),
        .count (errs)
    );

    assign locked = (st_q.mode == TRACKING);

    // R2
    disarm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!locked && errs == '0));

    // R3
    lock_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(smp_valid && smp == '0 && enable));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !smp_valid) |=> ($stable(locked) && $stable(errs)));

    // R5
    tally_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> (errs >= $past(errs)));
endmodule

// File: rtl/ramp_chk_top.sv
module ramp_chk_top #(
    parameter int SMP_W = 14,
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_i,
    input  logic [SMP_W-1:0] smp_q,
    output logic             lock_i,
    output logic             lock_q,
    output logic [ERR_W-1:0] errs_i,
    output logic [ERR_W-1:0] errs_q
);
    localparam int LANES = 2;

    logic [SMP_W-1:0] lane_smp  [LANES];
    logic             lane_lock [LANES];
    logic [ERR_W-1:0] lane_errs [LANES];

    assign lane_smp[0] = smp_i;
    assign lane_smp[1] = smp_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ramp_lane #(.SMP_W(SMP_W), .ERR_W(ERR_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (enable),
            .smp_valid (smp_valid),
            .smp       (lane_smp[g]),
            .locked    (lane_lock[g]),
            .errs      (lane_errs[g])
        );
    end

    assign lock_i = lane_lock[0];
    assign lock_q = lane_lock[1];
    assign errs_i = lane_errs[0];
    assign errs_q = lane_errs[1];

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!lock_i && !lock_q && errs_i == '0 && errs_q == '0));
endmodule

// File: tb/ramp_chk_top_tb.sv
module ramp_chk_top_tb;
    localparam int SW   = 4;
    localparam int EW   = 3;
    localparam int MODV = 1 << SW;
    localparam int EMAX = (1 << EW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_i = '0;
    logic [SW-1:0] smp_q = '0;
    logic          lock_i, lock_q;
    logic [EW-1:0] errs_i, errs_q;

    int n_vec = 0;
    int n_bad = 0;
    int m_lock [2];
    int m_exp  [2];
    int m_err  [2];

    always #2 clk = ~clk;

    ramp_chk_top #(.SMP_W(SW), .ERR_W(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
        .smp_i(smp_i), .smp_q(smp_q), .lock_i(lock_i), .lock_q(lock_q),
        .errs_i(errs_i), .errs_q(errs_q)
    );

    task automatic model_step(input int l, input bit en, input bit v, input int s);
        if (!en) begin
            m_lock[l] = 0; m_err[l] = 0; m_exp[l] = 0;
        end else if (v) begin
            if (m_lock[l] == 0) begin
                if (s == 0) begin m_lock[l] = 1; m_exp[l] = 1; end
            end else begin
                if (s != m_exp[l] && m_err[l] < EMAX) m_err[l] = m_err[l] + 1;
                m_exp[l] = (s + 1) % MODV;
            end
        end
    endtask

    task automatic compare(input string tag);
        n_vec++;
        if (lock_i !== m_lock[0][0] || int'(errs_i) != m_err[0] ||
            lock_q !== m_lock[1][0] || int'(errs_q) != m_err[1]) begin
            n_bad++;
            $display("FAIL %s: lock_i=%0b errs_i=%0d lock_q=%0b errs_q=%0d expected %0d %0d %0d %0d",
                     tag, lock_i, errs_i, lock_q, errs_q, m_lock[0], m_err[0], m_lock[1], m_err[1]);
        end
    endtask

    // called at a negedge; applies inputs, clocks once, checks at the next negedge
    task automatic cyc(input bit en, input bit v, input int si, input int sq, input string tag);
        enable = en; smp_valid = v; smp_i = SW'(si); smp_q = SW'(sq);
        @(posedge clk);
        model_step(0, en, v, si);
        model_step(1, en, v, sq);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int l = 0; l < 2; l++) begin m_lock[l] = 0; m_exp[l] = 0; m_err[l] = 0; end
        @(negedge clk);
        compare("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 1, 0, 0, "R1 after reset");
        cyc(0, 1, 0, 0, "R2 zero while disabled");

        // clean ramp with wraps on I; Q held at all-ones never locks
        for (int k = 0; k < 40; k++) cyc(1, 1, (9 + k) % MODV, MODV - 1, "R4 R3 wrap and all-ones");

        // valid low with garbage
        for (int k = 0; k < 10; k++) cyc(1, 0, (k * 7) % MODV, k % MODV, "R7 invalid ignored");
        // continue I ramp where it left off: last sample (9+39)%16 = 0
        for (int k = 1; k < 6; k++) cyc(1, 1, k, MODV - 1, "R7 expected value kept");

        // single slip on I: skip ahead by 3
        for (int k = 9; k < 20; k++) cyc(1, 1, k % MODV, MODV - 1, "R5 single slip");

        // every slip distance on Q, I clean
        for (int d = 1; d < MODV; d++) begin
            cyc(0, 1, 0, 0, "R2 re-arm");
            for (int k = 0; k < 6; k++) cyc(1, 1, k, k, "R8 pre-slip");
            for (int k = 0; k < 8; k++) cyc(1, 1, 6 + k, (6 + d + k) % MODV, "R8 slip sweep");
        end

        // saturation: constant nonzero after lock
        cyc(0, 1, 0, 0, "R2 re-arm");
        cyc(1, 1, 0, MODV - 1, "R3 lock");
        for (int k = 0; k < 12; k++) cyc(1, 1, 3, 0, "R6 saturate");
        for (int k = 0; k < 5; k++) cyc(1, 0, 3, 3, "R7 hold at max");
        cyc(0, 0, 0, 0, "R2 clear");
        for (int k = 0; k < 4; k++) cyc(0, 1, 0, 0, "R2 no lock disabled");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule